// File: doc/BRIEF.md
# Multimaster Priority Bus Arbiter

This block decides which of several bus masters owns the shared address path of a synchronous, non-multiplexed local bus. Every master drives a request, a 2-bit priority, a lock flag, a read/write flag, a 3-bit fixed burst length and a 32-bit address. The arbiter picks one owner, drives that owner's address and control to the slaves, and waits for a slave to acknowledge the address. When the acknowledge arrives, the master is told through a one-cycle acknowledge pulse.

Read and write data tenures are tracked separately, so one read and one write can be in flight together, even when both come from the same master. The pipeline depth is one outstanding read and one outstanding write. An address whose data path is still busy is held back until the slave reports that path done.

The choice of the next owner is made in the same cycle the current address is acknowledged, so the next address appears in the following cycle. A master that sets its lock flag on an accepted transfer keeps every other master out for as long as it holds the flag.

Top module: `bus_arbiter`

## Requirements
- R1: During and after reset, no master is granted, no acknowledge pulses, the address-valid output is 0, and both data-busy flags are 0.
- R2: With no current owner, a requesting master is chosen, and from the next cycle it sees a one-hot grant (bit i for master i). While the address is valid, `bMaster`, `bAddr`, `bRnW`, `bBurst` (the 3-bit burst field, passed unchanged) and `bLock` follow that master's inputs. When the address is not valid they are all zero.
- R3: Among eligible requesters, the one with the numerically largest 2-bit priority wins (3 is highest).
- R4: Ties at the top priority are broken round-robin. The search starts at the master after the last one granted, and master 0 is first after reset.
- R5: The owner's address is acknowledged (`mAddrAck` bit of the owner, for one cycle) exactly in a cycle when the address is valid, `sAddrAck` is 1, and the matching data path is free. A read (`bRnW`=1) needs the read path free and a write needs the write path free. Otherwise the owner keeps waiting.
- R6: An accepted read sets the read-busy flag from the next cycle and records the master in `rdOwner`. The flag stays set until a cycle with `sRdDone`=1 and clears after it. `sRdDone` while the path is idle has no effect. The write path behaves the same way with `sWrDone` and `wrOwner`.
- R7: A read tenure and a write tenure can be busy at the same time, each with its own owner.
- R8: Arbitration happens in the cycle an address is acknowledged, so the next owner is granted in the very next cycle. The master just acknowledged is not eligible in that arbitration unless it holds the lock.
- R9: If an accepted transfer carries the lock flag, only that master is eligible while its lock input stays 1. The lock ends as soon as that input drops.
- R10: Priority is sampled only when arbitrating. The owner keeps the grant until its address is acknowledged, even if a higher-priority request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mReq | input | NUM_MASTERS | Request per master |
| mPrio | input | 2*NUM_MASTERS | 2-bit priority per master |
| mLock | input | NUM_MASTERS | Lock flag per master |
| mRnW | input | NUM_MASTERS | 1 = read, 0 = write |
| mBurst | input | 3*NUM_MASTERS | Fixed burst length per master |
| mAddr | input | ADDR_W*NUM_MASTERS | Address per master |
| sAddrAck | input | 1 | Slave accepts the presented address |
| sRdDone | input | 1 | Read data tenure finished |
| sWrDone | input | 1 | Write data tenure finished |
| mGrant | output | NUM_MASTERS | One-hot current address owner |
| mAddrAck | output | NUM_MASTERS | One-hot address acknowledge pulse |
| bAddrValid | output | 1 | Address phase active |
| bAddr | output | ADDR_W | Address to the slaves |
| bRnW | output | 1 | Direction to the slaves |
| bBurst | output | 3 | Burst length to the slaves |
| bLock | output | 1 | Lock flag to the slaves |
| bMaster | output | ID_W | Index of the owner |
| rdBusy | output | 1 | Read data tenure in flight |
| rdOwner | output | ID_W | Master of the read tenure |
| wrBusy | output | 1 | Write data tenure in flight |
| wrOwner | output | ID_W | Master of the write tenure |

## Verification
The bench targets a higher-priority request that arrives while another master owns the path. A preempting design would move the grant before the owner's acknowledge. It checks round-robin wrap among equal priorities: a design that restarted at master 0 or reused the last winner would grant the wrong bit. It holds a second read while the read path is busy, which an unguarded design would acknowledge early and so corrupt `rdOwner`. It also holds a locked master against a priority-3 rival, and a design that ignored the lock or never released it would grant the rival too early or never.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int PRIO_W  = 2;
  localparam int BURST_W = 3;

  // strobes sent from the control to the datapath
  typedef struct packed {
    logic addrEnable;
    logic ownerLoad;
    logic rdLoad;
    logic wrLoad;
  } arbStrobe_t;
endpackage

// File: rtl/arb_select.sv
module arb_select
  import arb_pkg::*;
#(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [N-1:0]        eligible,
  input  logic [N*PRIO_W-1:0] prio,
  input  logic [IDW-1:0]      lastId,
  output logic                winValid,
  output logic [IDW-1:0]      winId
);
  logic [PRIO_W-1:0] topPrio;
  logic              found;
  int                idx;

  always_comb begin
    topPrio = '0;
    for (int i = 0; i < N; i++) begin
      if (eligible[i] && (prio[i*PRIO_W +: PRIO_W] > topPrio))
        topPrio = prio[i*PRIO_W +: PRIO_W];
    end
    winValid = |eligible;
    winId    = '0;
    found    = 1'b0;
    idx      = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(lastId) + k) % N;
      if (!found && eligible[idx] && (prio[idx*PRIO_W +: PRIO_W] == topPrio)) begin
        found = 1'b1;
        winId = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N-1:0]        mReq,
  input  logic [N*PRIO_W-1:0] mPrio,
  input  logic [N-1:0]        mLock,
  input  logic [IDW-1:0]      ownerId,
  input  logic                ownerRnW,
  input  logic                sAddrAck,
  input  logic                sRdDone,
  input  logic                sWrDone,
  output arbStrobe_t          strobe,
  output logic [IDW-1:0]      newOwner,
  output logic [N-1:0]        mGrant,
  output logic [N-1:0]        mAddrAck,
  output logic                rdBusy,
  output logic                wrBusy
);
  localparam logic [N-1:0] ONE_HOT0 = {{(N-1){1'b0}}, 1'b1};

  logic           ownerValid;
  logic           lockActive;
  logic [IDW-1:0] lockId;
  logic [IDW-1:0] lastId;
  logic           accept;
  logic           acceptLock;
  logic           lockEff;
  logic           lockNow;
  logic [IDW-1:0] lockNowId;
  logic [N-1:0]   ownerHot;
  logic [N-1:0]   lockHot;
  logic [N-1:0]   eligible;
  logic           arbNow;
  logic           winValid;
  logic [IDW-1:0] winId;

  assign ownerHot   = ONE_HOT0 << ownerId;
  assign accept     = ownerValid && sAddrAck && (ownerRnW ? !rdBusy : !wrBusy);
  assign acceptLock = accept && mLock[ownerId];
  assign lockEff    = lockActive && mLock[lockId];
  assign lockNow    = lockEff || acceptLock;
  assign lockNowId  = lockEff ? lockId : ownerId;
  assign lockHot    = ONE_HOT0 << lockNowId;
  assign arbNow     = !ownerValid || accept;

  always_comb begin
    if (lockNow)     eligible = mReq & lockHot;
    else if (accept) eligible = mReq & ~ownerHot;
    else             eligible = mReq;
  end

  arb_select #(.N(N), .IDW(IDW)) u_select (
    .eligible (eligible),
    .prio     (mPrio),
    .lastId   (lastId),
    .winValid (winValid),
    .winId    (winId)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerValid <= 1'b0;
      lastId     <= IDW'(N - 1);
      lockActive <= 1'b0;
      lockId     <= '0;
      rdBusy     <= 1'b0;
      wrBusy     <= 1'b0;
    end else begin
      if (arbNow) begin
        ownerValid <= winValid;
        if (winValid) lastId <= winId;
      end
      lockActive <= lockNow;
      lockId     <= lockNowId;
      if (accept && ownerRnW) rdBusy <= 1'b1;
      else if (sRdDone)       rdBusy <= 1'b0;
      if (accept && !ownerRnW) wrBusy <= 1'b1;
      else if (sWrDone)        wrBusy <= 1'b0;
    end
  end

  always_comb begin
    strobe.addrEnable = ownerValid;
    strobe.ownerLoad  = arbNow && winValid;
    strobe.rdLoad     = accept && ownerRnW;
    strobe.wrLoad     = accept && !ownerRnW;
    newOwner          = winId;
    mGrant            = ownerValid ? ownerHot : '0;
    mAddrAck          = accept ? ownerHot : '0;
  end

  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ownerValid && !accept) |=> (ownerValid && $stable(ownerId))); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdBusy && !sRdDone) |=> rdBusy); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrBusy && !sWrDone) |=> wrBusy); // R6
  AST_LOCK_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    (lockNow && winValid) |-> (winId == lockNowId)); // R9
  AST_EXCLUDE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !lockNow && winValid) |-> (winId != ownerId)); // R8
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int N   = 4,
  parameter int AW  = 32,
  parameter int IDW = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arbStrobe_t           strobe,
  input  logic [IDW-1:0]       newOwner,
  input  logic [N-1:0]         mRnW,
  input  logic [N*BURST_W-1:0] mBurst,
  input  logic [N*AW-1:0]      mAddr,
  input  logic [N-1:0]         mLock,
  output logic [IDW-1:0]       ownerId,
  output logic [AW-1:0]        bAddr,
  output logic                 bRnW,
  output logic [BURST_W-1:0]   bBurst,
  output logic                 bLock,
  output logic [IDW-1:0]       bMaster,
  output logic [IDW-1:0]       rdOwner,
  output logic [IDW-1:0]       wrOwner
);
  logic [N-1:0]         hit;
  logic [AW-1:0]        addrTerm  [N];
  logic [BURST_W-1:0]   burstTerm [N];
  logic [N-1:0]         rnwTerm;
  logic [N-1:0]         lockTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerId <= '0;
      rdOwner <= '0;
      wrOwner <= '0;
    end else begin
      if (strobe.ownerLoad) ownerId <= newOwner;
      if (strobe.rdLoad)    rdOwner <= ownerId;
      if (strobe.wrLoad)    wrOwner <= ownerId;
    end
  end

  // AND-OR multiplexer, one leg per master
  for (genvar g = 0; g < N; g++) begin : g_leg
    assign hit[g]       = strobe.addrEnable && (ownerId == IDW'(g));
    assign addrTerm[g]  = hit[g] ? mAddr[g*AW +: AW] : '0;
    assign burstTerm[g] = hit[g] ? mBurst[g*BURST_W +: BURST_W] : '0;
    assign rnwTerm[g]   = hit[g] && mRnW[g];
    assign lockTerm[g]  = hit[g] && mLock[g];
  end

  always_comb begin
    bAddr  = '0;
    bBurst = '0;
    for (int i = 0; i < N; i++) begin
      bAddr  = bAddr | addrTerm[i];
      bBurst = bBurst | burstTerm[i];
    end
    bRnW    = |rnwTerm;
    bLock   = |lockTerm;
    bMaster = strobe.addrEnable ? ownerId : '0;
  end

  AST_RDOWNER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdLoad |=> $stable(rdOwner)); // R6
  AST_WROWNER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrLoad |=> $stable(wrOwner)); // R6
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 32,
  localparam int ID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_MASTERS-1:0]         mReq,
  input  logic [NUM_MASTERS*PRIO_W-1:0]  mPrio,
  input  logic [NUM_MASTERS-1:0]         mLock,
  input  logic [NUM_MASTERS-1:0]         mRnW,
  input  logic [NUM_MASTERS*BURST_W-1:0] mBurst,
  input  logic [NUM_MASTERS*ADDR_W-1:0]  mAddr,
  input  logic                           sAddrAck,
  input  logic                           sRdDone,
  input  logic                           sWrDone,
  output logic [NUM_MASTERS-1:0]         mGrant,
  output logic [NUM_MASTERS-1:0]         mAddrAck,
  output logic                           bAddrValid,
  output logic [ADDR_W-1:0]              bAddr,
  output logic                           bRnW,
  output logic [BURST_W-1:0]             bBurst,
  output logic                           bLock,
  output logic [ID_W-1:0]                bMaster,
  output logic                           rdBusy,
  output logic [ID_W-1:0]                rdOwner,
  output logic                           wrBusy,
  output logic [ID_W-1:0]                wrOwner
);
  arbStrobe_t      strobe;
  logic [ID_W-1:0] newOwner;
  logic [ID_W-1:0] ownerId;

  arb_ctrl #(.N(NUM_MASTERS), .IDW(ID_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mReq     (mReq),
    .mPrio    (mPrio),
    .mLock    (mLock),
    .ownerId  (ownerId),
    .ownerRnW (bRnW),
    .sAddrAck (sAddrAck),
    .sRdDone  (sRdDone),
    .sWrDone  (sWrDone),
    .strobe   (strobe),
    .newOwner (newOwner),
    .mGrant   (mGrant),
    .mAddrAck (mAddrAck),
    .rdBusy   (rdBusy),
    .wrBusy   (wrBusy)
  );

  arb_datapath #(.N(NUM_MASTERS), .AW(ADDR_W), .IDW(ID_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .newOwner (newOwner),
    .mRnW     (mRnW),
    .mBurst   (mBurst),
    .mAddr    (mAddr),
    .mLock    (mLock),
    .ownerId  (ownerId),
    .bAddr    (bAddr),
    .bRnW     (bRnW),
    .bBurst   (bBurst),
    .bLock    (bLock),
    .bMaster  (bMaster),
    .rdOwner  (rdOwner),
    .wrOwner  (wrOwner)
  );

  assign bAddrValid = strobe.addrEnable;

  AST_GRANT_ACK_SAME: assert property (@(posedge clk) disable iff (!rstN)
    (|mAddrAck) |-> (bAddrValid && (mAddrAck == mGrant))); // R5
endmodule

// File: tb/tb_bus_arbiter.sv
module tb_bus_arbiter;
  localparam int  N          = 4;
  localparam int  AW         = 32;
  localparam int  IDW        = 2;
  localparam time CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N-1:0]   mReq = '0;
  logic [N*2-1:0] mPrio = '0;
  logic [N-1:0]   mLock = '0;
  logic [N-1:0]   mRnW = '0;
  logic [N*3-1:0] mBurst = '0;
  logic [N*AW-1:0] mAddr = '0;
  logic           sAddrAck = 1'b0;
  logic           sRdDone = 1'b0;
  logic           sWrDone = 1'b0;
  logic [N-1:0]   mGrant, mAddrAck;
  logic           bAddrValid, bRnW, bLock, rdBusy, wrBusy;
  logic [AW-1:0]  bAddr;
  logic [2:0]     bBurst;
  logic [IDW-1:0] bMaster, rdOwner, wrOwner;

  bus_arbiter #(.NUM_MASTERS(N), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mPrio(mPrio), .mLock(mLock),
    .mRnW(mRnW), .mBurst(mBurst), .mAddr(mAddr), .sAddrAck(sAddrAck),
    .sRdDone(sRdDone), .sWrDone(sWrDone), .mGrant(mGrant), .mAddrAck(mAddrAck),
    .bAddrValid(bAddrValid), .bAddr(bAddr), .bRnW(bRnW), .bBurst(bBurst),
    .bLock(bLock), .bMaster(bMaster), .rdBusy(rdBusy), .rdOwner(rdOwner),
    .wrBusy(wrBusy), .wrOwner(wrOwner)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int     nCmp = 0;
  int     nBad = 0;
  string  phase = "R1 reset";
  logic [N-1:0] ackSeen = '0;
  logic [N-1:0] keepReq = '0;
  bit     done = 0;

  // reference model state
  int own = -1, last = N-1, lockId = 0, rdO = 0, wrO = 0;
  bit lockAct = 0, rdB = 0, wrB = 0;
  int nOwn = -1, nLast = N-1, nLockId = 0, nRdO = 0, nWrO = 0;
  bit nLockAct = 0, nRdB = 0, nWrB = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int prioOf(int i);
    return int'(mPrio[i*2 +: 2]);
  endfunction

  always @(negedge clk) begin : model
    logic [N-1:0] eGrant, eAck;
    logic [63:0]  expV, actV;
    logic [AW-1:0] eAddr;
    logic [2:0]   eBurst;
    logic         eRnW, eLock;
    logic [IDW-1:0] eMaster;
    bit acc, lk;
    int lid, best, bp, i;
    ackSeen = mAddrAck;
    acc = (own >= 0) && sAddrAck && (mRnW[own] ? !rdB : !wrB);
    eGrant = '0; eAddr = '0; eBurst = '0; eRnW = 0; eLock = 0; eMaster = '0;
    if (own >= 0) begin
      eGrant  = 4'b0001 << own;
      eAddr   = mAddr[own*AW +: AW];
      eBurst  = mBurst[own*3 +: 3];
      eRnW    = mRnW[own];
      eLock   = mLock[own];
      eMaster = IDW'(own);
    end
    eAck = acc ? eGrant : '0;
    expV = {10'd0, eGrant, eAck, own >= 0, eAddr, eRnW, eBurst, eLock, eMaster,
            rdB, IDW'(rdO), wrB, IDW'(wrO)};
    actV = {10'd0, mGrant, mAddrAck, bAddrValid, bAddr, bRnW, bBurst, bLock, bMaster,
            rdBusy, rdOwner, wrBusy, wrOwner};
    if (!done) check({phase, " model"}, actV, expV);
    // next state
    lk = 0; lid = lockId;
    if (lockAct && mLock[lockId]) begin lk = 1; lid = lockId; end
    else if (acc && mLock[own]) begin lk = 1; lid = own; end
    nOwn = own; nLast = last;
    if (own < 0 || acc) begin
      best = -1; bp = -1;
      for (int k = 1; k <= N; k++) begin
        i = (last + k) % N;
        if (mReq[i] && (lk ? (i == lid) : !(acc && i == own)) && prioOf(i) > bp) begin
          best = i; bp = prioOf(i);
        end
      end
      nOwn = best;
      if (best >= 0) nLast = best;
    end
    nLockAct = lk; nLockId = lid;
    nRdB = rdB; nRdO = rdO; nWrB = wrB; nWrO = wrO;
    if (acc && mRnW[own]) begin nRdB = 1; nRdO = own; end
    else if (sRdDone) nRdB = 0;
    if (acc && !mRnW[own]) begin nWrB = 1; nWrO = own; end
    else if (sWrDone) nWrB = 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      own = -1; last = N-1; lockId = 0; rdO = 0; wrO = 0;
      lockAct = 0; rdB = 0; wrB = 0;
    end else begin
      own = nOwn; last = nLast; lockId = nLockId; rdO = nRdO; wrO = nWrO;
      lockAct = nLockAct; rdB = nRdB; wrB = nWrB;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++)
      if (ackSeen[i] && !keepReq[i]) mReq[i] = 1'b0;
  endtask

  task automatic setMaster(int i, int p, bit rnw, int burst, logic [AW-1:0] a);
    mReq[i] = 1'b1;
    mPrio[i*2 +: 2] = 2'(p);
    mRnW[i] = rnw;
    mBurst[i*3 +: 3] = 3'(burst);
    mAddr[i*AW +: AW] = a;
  endtask

  task automatic drain();
    mReq = '0; mLock = '0; keepReq = '0;
    sAddrAck = 1'b1; sRdDone = 1'b1; sWrDone = 1'b1;
    repeat (5) tick();
  endtask

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    bit got;
    repeat (3) tick();
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {mGrant, mAddrAck, bAddrValid, rdBusy, wrBusy}, '0);

    // priority, field mirroring, no preemption, round-robin
    phase = "R3 R4 R10 priority";
    sRdDone = 1'b1; sWrDone = 1'b1; sAddrAck = 1'b0;
    tick();
    setMaster(0, 1, 0, 2, 32'h1000_0000);
    setMaster(2, 3, 0, 5, 32'hA0B0_C0D2);
    tick();
    @(negedge clk);
    check("R3 highest priority granted", mGrant, 4'b0100);
    check("R2 address and burst mirrored", {bAddr, bBurst, bRnW, bMaster}, {32'hA0B0_C0D2, 3'd5, 1'b0, 2'd2});
    tick();
    setMaster(3, 3, 1, 7, 32'h3333_0000);
    mPrio[1:0] = 2'd3;
    tick(); tick();
    @(negedge clk);
    check("R10 owner kept despite new priority", mGrant, 4'b0100);
    tick();
    sAddrAck = 1'b1;
    @(negedge clk);
    check("R5 acknowledge to owner", mAddrAck, 4'b0100);
    tick();
    sAddrAck = 1'b0;
    @(negedge clk);
    check("R8 R4 next owner after last granted", mGrant, 4'b1000);
    tick();
    sAddrAck = 1'b1;
    @(negedge clk);
    check("R5 read accepted", mAddrAck, 4'b1000);
    tick();
    sAddrAck = 1'b0;
    @(negedge clk);
    check("R4 round-robin wraps", mGrant, 4'b0001);
    drain();

    // concurrent tenures and busy blocking
    phase = "R5 R6 R7 tenures";
    sRdDone = 1'b0; sWrDone = 1'b0; sAddrAck = 1'b1;
    setMaster(1, 2, 1, 1, 32'h0000_1111);
    setMaster(3, 1, 0, 3, 32'h0000_3333);
    tick(); tick(); tick();
    @(negedge clk);
    check("R7 read and write in flight", {rdBusy, rdOwner, wrBusy, wrOwner}, {1'b1, 2'd1, 1'b1, 2'd3});
    tick();
    setMaster(1, 2, 1, 4, 32'h0000_1112);
    tick(); tick();
    @(negedge clk);
    check("R5 read held while read path busy", {mGrant, mAddrAck}, {4'b0010, 4'b0000});
    tick();
    sRdDone = 1'b1;
    tick();
    sRdDone = 1'b0;
    @(negedge clk);
    check("R6 read path freed then accepted", mAddrAck, 4'b0010);
    check("R6 write busy holds without done", wrBusy, 1'b1);
    drain();

    // lock
    phase = "R9 lock";
    keepReq = 4'b0001;
    setMaster(0, 0, 0, 0, 32'h0000_00A0);
    mLock[0] = 1'b1;
    tick();
    setMaster(1, 3, 1, 0, 32'h0000_00B1);
    for (int n = 0; n < 6; n++) begin
      tick();
      @(negedge clk);
      check("R9 locked master keeps rival out", mGrant, 4'b0001);
    end
    tick();
    mLock[0] = 1'b0; keepReq = '0; mReq[0] = 1'b0;
    got = 0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (mAddrAck[1]) got = 1;
      tick();
    end
    check("R9 rival served after lock release", got, 1'b1);
    drain();

    // mixed traffic
    phase = "R2 R6 R8 R9 mixed";
    for (int c = 0; c < 3000; c++) begin
      tick();
      sAddrAck = 1'($urandom % 2);
      sRdDone  = ($urandom % 3) == 0;
      sWrDone  = ($urandom % 3) == 0;
      for (int i = 0; i < N; i++) begin
        if (!mReq[i] && mLock[i] && ($urandom % 4) == 0) mLock[i] = 1'b0;
        if (!mReq[i] && ($urandom % 3) == 0) begin
          setMaster(i, int'($urandom % 4), 1'($urandom % 2), int'($urandom % 8), $urandom);
          mLock[i] = ($urandom % 6) == 0;
        end
      end
    end
    drain();
    @(negedge clk);
    finishRun();
  end
endmodule